// File: doc/BRIEF.md
# Big-Endian Bus Peripheral Slave Adapter

This block places a simple synchronous peripheral port (word address, four byte enables, 32-bit data each way) in one address window of a 32-bit synchronous processor bus. That bus numbers its bits big-endian and frames every access with a one-cycle start strobe and a one-cycle acknowledge. The adapter compares the upper address bits against a base set by a parameter. It ignores accesses that fall outside the window. For each access it accepts, it waits a fixed number of cycles set by a parameter, performs one access on the peripheral port and then acknowledges.

Narrow accesses use the most significant lanes of the bus. A byte travels on bus bits 0..7 and a halfword on bus bits 0..15. The adapter moves this data to the peripheral lane that the low address bits select, and moves read data back in the same way. When the master flags a cache-line burst, the adapter serves only the first word. It raises a burst-refusal signal together with its acknowledge, and the master then issues the remaining words as ordinary single accesses.

In the port list, vector index 31 is bus bit 0, the most significant bit. Peripheral byte enable `per_be[3]` covers `per_wdata[31:24]` and `per_rdata[31:24]`, which is byte offset 0 within the word.

Top module: `bus_slave_bridge`

## Requirements
- R1: A start whose address bits [31:REGION_BITS] differ from those of `BASE_ADDR` produces no acknowledge, no burst refusal and no peripheral access.
- R2: For an accepted start sampled in cycle 0, `bus_ack` is high in cycle `WAIT_STATES`+2 only, for exactly one cycle.
- R3: Size code 2'b00 (word) uses all 32 data lines, sets `per_be`=4'b1111 and ignores address bits [1:0].
- R4: Size code 2'b10 (halfword) uses bus vector bits [31:16]. It sets `per_be`=4'b1100 when address bit 1 is 0 and 4'b0011 when it is 1, and ignores address bit 0.
- R5: Size code 2'b01 (byte) uses bus vector bits [31:24] and sets `per_be` = 4'b1000 shifted right by address bits [1:0].
- R6: `bus_rdata` is zero in every cycle without acknowledge. In the acknowledge cycle of a read it carries the selected peripheral lanes moved to the top of the bus, and every lane that carries no data is zero.
- R7: Each accepted access pulses `per_en` for one cycle, in cycle `WAIT_STATES`+1. `per_we` is high in that cycle for a write, `per_addr` equals address bits [REGION_BITS-1:2], and for a write `per_wdata` carries the bus lanes copied across every peripheral lane.
- R8: `bus_binh` is high exactly in the acknowledge cycle of an access whose start had `bus_burst` high, and it is low otherwise.
- R9: After a refused burst, the next start is accepted and completed as a normal single access without `bus_binh`.
- R10: Size code 2'b11 is handled exactly like a word access.
- R11: While `rst_n` is low, `bus_ack`, `bus_binh` and `per_en` stay low, and any start is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_start | input | 1 | One-cycle transfer start strobe |
| bus_addr | input | 32 | Byte address, valid with start |
| bus_size | input | 2 | Size code: 00 word, 01 byte, 10 half, 11 word |
| bus_read | input | 1 | 1 = read, 0 = write |
| bus_wdata | input | 32 | Write data, valid with start |
| bus_burst | input | 1 | Burst in progress, valid with start |
| bus_rdata | output | 32 | Read data, non-zero only with acknowledge |
| bus_ack | output | 1 | One-cycle transfer acknowledge |
| bus_binh | output | 1 | Burst refusal, given with acknowledge |
| per_en | output | 1 | Peripheral access strobe |
| per_we | output | 1 | Peripheral write enable |
| per_addr | output | REGION_BITS-2 | Peripheral word address |
| per_be | output | 4 | Peripheral byte enables |
| per_wdata | output | 32 | Peripheral write data |
| per_rdata | input | 32 | Peripheral read data, one cycle after `per_en` |

## Verification
The checker assumes that the master never raises `bus_start` while an accepted access is still waiting for its acknowledge, and that the peripheral returns read data in the cycle after `per_en`. The stimulus keeps to both rules. Each access is issued alone and allowed to finish before the next start, and the bench's peripheral model is a memory with a one-cycle registered read. The address, size, read/write and burst inputs are assumed to matter only in the start cycle, so the bench drives them only in that cycle.

// File: rtl/pbs_pkg.sv
// Shared types for the bus slave adapter.
// Assumes a 32-bit bus of four byte lanes, lane 0 being the most significant.
package pbs_pkg;
    localparam int BUS_W = 32;
    localparam int LANES = BUS_W / 8;

    typedef enum logic [1:0] {
        SZ_WORD   = 2'b00,
        SZ_BYTE   = 2'b01,
        SZ_HALF   = 2'b10,
        SZ_TRIPLE = 2'b11
    } bus_size_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_WAIT,
        ST_ISSUE,
        ST_RESP
    } seq_state_e;

    // Extract byte lane k, where k=0 is the most significant byte.
    function automatic logic [7:0] lane_of(input logic [31:0] v, input logic [1:0] k);
        return v[31 - 8*k -: 8];
    endfunction
endpackage

// File: rtl/pbs_decode.sv
// Region decoder: flags addresses whose upper bits match the window base.
// Assumes the window is 2**REGION_BITS bytes and aligned to its size.
module pbs_decode #(
    parameter logic [31:0] BASE_ADDR   = 32'h4000_0000,
    parameter int          REGION_BITS = 12
) (
    input  logic [31-REGION_BITS:0] addr_hi,
    output logic                    hit
);
    localparam logic [31-REGION_BITS:0] BASE_HI = BASE_ADDR[31:REGION_BITS];

    // Compare the upper address bits with the base.
    assign hit = (addr_hi == BASE_HI);
endmodule

// File: rtl/pbs_lane.sv
// Lane steering: byte enables, write fan-out and read alignment.
// Assumes big-endian lanes; narrow data sits in the top bus lanes.
module pbs_lane
    import pbs_pkg::*;
(
    input  logic [1:0]       size,
    input  logic [1:0]       lo,
    input  logic [BUS_W-1:0] bus_w,
    input  logic [BUS_W-1:0] per_r,
    output logic [LANES-1:0] be,
    output logic [BUS_W-1:0] per_w,
    output logic [BUS_W-1:0] bus_r
);
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic [1:0] LI = 2'(g);
        localparam bit TOP_HALF = (g < 2);
        logic       be_l;
        logic [7:0] w_l;
        logic [7:0] r_l;

        // Choose enable, write byte and read byte for this lane.
        always_comb begin
            unique case (bus_size_e'(size))
                SZ_BYTE: begin
                    be_l = (lo == LI);
                    w_l  = lane_of(bus_w, 2'd0);
                    r_l  = (g == 0) ? lane_of(per_r, lo) : 8'h00;
                end
                SZ_HALF: begin
                    be_l = (lo[1] == LI[1]);
                    w_l  = lane_of(bus_w, {1'b0, LI[0]});
                    r_l  = TOP_HALF ? lane_of(per_r, {lo[1], LI[0]}) : 8'h00;
                end
                default: begin
                    be_l = 1'b1;
                    w_l  = lane_of(bus_w, LI);
                    r_l  = lane_of(per_r, LI);
                end
            endcase
        end

        assign be[LANES-1-g]           = be_l;
        assign per_w[BUS_W-1-8*g -: 8] = w_l;
        assign bus_r[BUS_W-1-8*g -: 8] = r_l;
    end
endmodule

// File: rtl/pbs_seq.sv
// Access sequencer: accept, count wait states, issue, respond.
// Assumes the master holds off new starts until the acknowledge.
module pbs_seq
    import pbs_pkg::*;
#(
    parameter int WAIT_STATES = 3
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic hit,
    output logic accept,
    output logic issue,
    output logic respond
);
    localparam int CW = (WAIT_STATES > 1) ? $clog2(WAIT_STATES + 1) : 1;
    localparam logic [CW-1:0] LOAD = CW'((WAIT_STATES > 0) ? WAIT_STATES - 1 : 0);

    seq_state_e    state;
    logic [CW-1:0] cnt;

    assign accept  = (state == ST_IDLE) && start && hit;
    assign issue   = (state == ST_ISSUE);
    assign respond = (state == ST_RESP);

    // Advance the access state and the wait counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            unique case (state)
                ST_IDLE: if (accept) begin
                    state <= (WAIT_STATES == 0) ? ST_ISSUE : ST_WAIT;
                    cnt   <= LOAD;
                end
                ST_WAIT: begin
                    if (cnt == '0) state <= ST_ISSUE;
                    else           cnt   <= cnt - 1'b1;
                end
                ST_ISSUE: state <= ST_RESP;
                default:  state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/bus_slave_bridge.sv
// Top: connects one peripheral window to a big-endian 32-bit bus.
// Assumes single accesses only; a burst gets its first word plus a refusal.
// Assumes per_rdata is valid the cycle after per_en.
module bus_slave_bridge
    import pbs_pkg::*;
#(
    parameter logic [31:0] BASE_ADDR   = 32'h4000_0000,
    parameter int          REGION_BITS = 12,
    parameter int          WAIT_STATES = 3
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   bus_start,
    input  logic [31:0]            bus_addr,
    input  logic [1:0]             bus_size,
    input  logic                   bus_read,
    input  logic [31:0]            bus_wdata,
    input  logic                   bus_burst,
    output logic [31:0]            bus_rdata,
    output logic                   bus_ack,
    output logic                   bus_binh,
    output logic                   per_en,
    output logic                   per_we,
    output logic [REGION_BITS-3:0] per_addr,
    output logic [3:0]             per_be,
    output logic [31:0]            per_wdata,
    input  logic [31:0]            per_rdata
);
    logic                   hit, accept, issue, respond;
    logic [REGION_BITS-1:0] addr_q;
    logic [1:0]             size_q;
    logic                   read_q, burst_q;
    logic [31:0]            wdata_q;
    logic [3:0]             be_c;
    logic [31:0]            rd_c;

    pbs_decode #(.BASE_ADDR(BASE_ADDR), .REGION_BITS(REGION_BITS)) u_dec (
        .addr_hi (bus_addr[31:REGION_BITS]),
        .hit     (hit)
    );

    pbs_seq #(.WAIT_STATES(WAIT_STATES)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .start   (bus_start),
        .hit     (hit),
        .accept  (accept),
        .issue   (issue),
        .respond (respond)
    );

    // Capture the access attributes when a start is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            size_q  <= '0;
            read_q  <= 1'b0;
            burst_q <= 1'b0;
            wdata_q <= '0;
        end else if (accept) begin
            addr_q  <= bus_addr[REGION_BITS-1:0];
            size_q  <= bus_size;
            read_q  <= bus_read;
            burst_q <= bus_burst;
            wdata_q <= bus_wdata;
        end
    end

    pbs_lane u_lane (
        .size  (size_q),
        .lo    (addr_q[1:0]),
        .bus_w (wdata_q),
        .per_r (per_rdata),
        .be    (be_c),
        .per_w (per_wdata),
        .bus_r (rd_c)
    );

    assign per_en    = issue;
    assign per_we    = issue && !read_q;
    assign per_be    = issue ? be_c : 4'h0;
    assign per_addr  = addr_q[REGION_BITS-1:2];
    assign bus_ack   = respond;
    assign bus_binh  = respond && burst_q;
    assign bus_rdata = (respond && read_q) ? rd_c : 32'h0;
endmodule

// File: rtl/pbs_checker.sv
// Protocol checker for bus_slave_bridge, attached with bind.
// Assumes no new start while an accepted access is outstanding.
module pbs_checker #(
    parameter logic [31:0] BASE_ADDR   = 32'h4000_0000,
    parameter int          REGION_BITS = 12,
    parameter int          WAIT_STATES = 3
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   bus_start,
    input logic [31-REGION_BITS:0] addr_hi,
    input logic                   bus_ack,
    input logic                   bus_binh,
    input logic [31:0]            bus_rdata,
    input logic                   per_en
);
    localparam logic [4:0] ACK_AT   = 5'(WAIT_STATES + 2);
    localparam logic [4:0] ISSUE_AT = 5'(WAIT_STATES + 1);

    logic       busy;
    logic [4:0] age;
    logic       in_win;

    assign in_win = (addr_hi == BASE_ADDR[31:REGION_BITS]);

    // Track the age of the outstanding access independently of the design.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            age  <= '0;
        end else if (!busy && bus_start && in_win) begin
            busy <= 1'b1;
            age  <= 5'd1;
        end else if (busy) begin
            if (bus_ack) busy <= 1'b0;
            age <= age + 5'd1;
        end
    end

    assert_miss_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && bus_start && !in_win) |=> !per_en);
    assert_ack_latency_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |-> (busy && age == ACK_AT));
    assert_ack_due_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && age == ACK_AT) |-> bus_ack);
    assert_ack_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
        bus_ack |=> !bus_ack);
    assert_rdata_quiet_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_ack |-> (bus_rdata == 32'h0));
    assert_issue_slot_R7: assert property (@(posedge clk) disable iff (!rst_n)
        per_en |-> (busy && age == ISSUE_AT));
    assert_binh_with_ack_R8: assert property (@(posedge clk) disable iff (!rst_n)
        bus_binh |-> bus_ack);
endmodule

bind bus_slave_bridge pbs_checker #(
    .BASE_ADDR   (BASE_ADDR),
    .REGION_BITS (REGION_BITS),
    .WAIT_STATES (WAIT_STATES)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_start (bus_start),
    .addr_hi   (bus_addr[31:REGION_BITS]),
    .bus_ack   (bus_ack),
    .bus_binh  (bus_binh),
    .bus_rdata (bus_rdata),
    .per_en    (per_en)
);

// File: tb/sim_bus_slave_bridge.sv
module sim_bus_slave_bridge;
    localparam int W = 3;

    typedef struct packed {
        logic [31:0] addr;
        logic [1:0]  size;
        logic        rd;
        logic        burst;
        logic        hit;
        logic [3:0]  be;
        logic [31:0] wd;
        logic [31:0] data;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t VECS [NV] = '{
        '{32'h4000_0010, 2'b00, 1'b0, 1'b0, 1'b1, 4'hF, 32'hDEADBEEF, 32'hDEADBEEF},
        '{32'h4000_0013, 2'b00, 1'b1, 1'b0, 1'b1, 4'hF, 32'h0,        32'hDEADBEEF},
        '{32'h4000_0022, 2'b10, 1'b0, 1'b0, 1'b1, 4'h3, 32'hABCD1234, 32'hABCDABCD},
        '{32'h4000_0021, 2'b10, 1'b0, 1'b0, 1'b1, 4'hC, 32'h55669999, 32'h55665566},
        '{32'h4000_0022, 2'b10, 1'b1, 1'b0, 1'b1, 4'h3, 32'h0,        32'hABCD0000},
        '{32'h4000_0020, 2'b10, 1'b1, 1'b0, 1'b1, 4'hC, 32'h0,        32'h55660000},
        '{32'h4000_0031, 2'b01, 1'b0, 1'b0, 1'b1, 4'h4, 32'h7E000000, 32'h7E7E7E7E},
        '{32'h4000_0033, 2'b01, 1'b0, 1'b0, 1'b1, 4'h1, 32'h99FFFFFF, 32'h99999999},
        '{32'h4000_0031, 2'b01, 1'b1, 1'b0, 1'b1, 4'h4, 32'h0,        32'h7E000000},
        '{32'h4000_0033, 2'b01, 1'b1, 1'b0, 1'b1, 4'h1, 32'h0,        32'h99000000},
        '{32'h4000_0030, 2'b01, 1'b1, 1'b0, 1'b1, 4'h8, 32'h0,        32'h00000000},
        '{32'h4000_0030, 2'b00, 1'b1, 1'b1, 1'b1, 4'hF, 32'h0,        32'h007E0099},
        '{32'h4000_0034, 2'b00, 1'b1, 1'b0, 1'b1, 4'hF, 32'h0,        32'h00000000},
        '{32'h4000_1000, 2'b00, 1'b1, 1'b0, 1'b0, 4'h0, 32'h0,        32'h00000000},
        '{32'h3FFF_FFFC, 2'b00, 1'b0, 1'b0, 1'b0, 4'h0, 32'h12345678, 32'h00000000},
        '{32'h4000_0040, 2'b11, 1'b0, 1'b0, 1'b1, 4'hF, 32'h01020304, 32'h01020304},
        '{32'h4000_0042, 2'b11, 1'b1, 1'b0, 1'b1, 4'hF, 32'h0,        32'h01020304}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_start = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [1:0]  bus_size = '0;
    logic        bus_read = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic        bus_burst = 1'b0;
    logic [31:0] bus_rdata;
    logic        bus_ack, bus_binh, per_en, per_we;
    logic [9:0]  per_addr;
    logic [3:0]  per_be;
    logic [31:0] per_wdata;
    logic [31:0] per_rdata;

    logic        s1_start = 1'b0;
    logic [31:0] s1_rdata;
    logic        s1_ack, s1_binh, s1_en, s1_we;
    logic [9:0]  s1_paddr;
    logic [3:0]  s1_be;
    logic [31:0] s1_pw;

    int total = 0;
    int fails = 0;
    int cycles = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    bus_slave_bridge #(.BASE_ADDR(32'h4000_0000), .REGION_BITS(12), .WAIT_STATES(W)) u0 (
        .clk(clk), .rst_n(rst_n), .bus_start(bus_start), .bus_addr(bus_addr),
        .bus_size(bus_size), .bus_read(bus_read), .bus_wdata(bus_wdata),
        .bus_burst(bus_burst), .bus_rdata(bus_rdata), .bus_ack(bus_ack),
        .bus_binh(bus_binh), .per_en(per_en), .per_we(per_we), .per_addr(per_addr),
        .per_be(per_be), .per_wdata(per_wdata), .per_rdata(per_rdata)
    );

    bus_slave_bridge #(.BASE_ADDR(32'h4000_0000), .REGION_BITS(12), .WAIT_STATES(0)) u1 (
        .clk(clk), .rst_n(rst_n), .bus_start(s1_start), .bus_addr(32'h4000_0008),
        .bus_size(2'b00), .bus_read(1'b1), .bus_wdata(32'h0),
        .bus_burst(1'b0), .bus_rdata(s1_rdata), .bus_ack(s1_ack),
        .bus_binh(s1_binh), .per_en(s1_en), .per_we(s1_we), .per_addr(s1_paddr),
        .per_be(s1_be), .per_wdata(s1_pw), .per_rdata(32'hCAFEF00D)
    );

    // Peripheral model: byte-enabled memory with a one-cycle registered read.
    logic [31:0] mem [1024];
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 1024; i++) mem[i] <= 32'h0;
            per_rdata <= 32'h0;
        end else if (per_en) begin
            if (per_we) begin
                for (int b = 0; b < 4; b++)
                    if (per_be[b]) mem[per_addr][8*b +: 8] <= per_wdata[8*b +: 8];
            end else begin
                per_rdata <= mem[per_addr];
            end
        end
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string size_tag(input logic [1:0] s);
        case (s)
            2'b00:   return "R3";
            2'b10:   return "R4";
            2'b01:   return "R5";
            default: return "R10";
        endcase
    endfunction

    task automatic run_vec(input vec_t v);
        int ack_n = 0, ack_c = 0, en_n = 0, en_c = 0;
        bit quiet = 1'b1;
        logic [31:0] rdat = '0, wdat = '0;
        logic [3:0] be = '0;
        logic we = 1'b0, binh = 1'b0;
        logic [9:0] pa = '0;
        @(negedge clk);
        bus_start = 1'b1; bus_addr = v.addr; bus_size = v.size;
        bus_read = v.rd; bus_wdata = v.wd; bus_burst = v.burst;
        for (int c = 1; c <= W + 4; c++) begin
            @(negedge clk);
            if (c == 1) begin
                bus_start = 1'b0; bus_addr = '0; bus_wdata = '0; bus_burst = 1'b0;
            end
            if (per_en) begin
                en_n++; en_c = c; be = per_be; we = per_we; wdat = per_wdata; pa = per_addr;
            end
            if (bus_ack) begin
                ack_n++; ack_c = c; rdat = bus_rdata; binh = bus_binh;
            end else if (bus_rdata != 32'h0 || bus_binh) begin
                quiet = 1'b0;
            end
        end
        check(quiet, "R6 quiet rdata/binh outside ack", 32'(quiet), 32'h1);
        if (!v.hit) begin
            check(ack_n == 0 && en_n == 0, "R1 miss ignored", 32'(ack_n + en_n), 32'h0);
        end else begin
            check(ack_n == 1 && ack_c == W + 2, "R2 ack cycle", 32'(ack_c), 32'(W + 2));
            check(en_n == 1 && en_c == W + 1, "R7 issue cycle", 32'(en_c), 32'(W + 1));
            check(pa == v.addr[11:2], "R7 per_addr", 32'(pa), 32'(v.addr[11:2]));
            check(be == v.be, {size_tag(v.size), " byte enables"}, 32'(be), 32'(v.be));
            check(binh == v.burst, "R8/R9 burst refusal", 32'(binh), 32'(v.burst));
            if (v.rd) begin
                check(!we, "R7 no write on read", 32'(we), 32'h0);
                check(rdat == v.data, {size_tag(v.size), " R6 read data"}, rdat, v.data);
            end else begin
                check(we, "R7 write strobe", 32'(we), 32'h1);
                check(wdat == v.data, {size_tag(v.size), " R7 write data"}, wdat, v.data);
            end
        end
    endtask

    // Watchdog: an expired run counts as a failed check.
    always @(posedge clk) begin
        cycles++;
        if (cycles > 20000 && !done) begin
            done = 1'b1;
            total++; fails++;
            $display("FAIL watchdog actual=%0d expected<20000", cycles);
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        // R11: starts during reset are ignored.
        @(negedge clk);
        bus_start = 1'b1; bus_addr = 32'h4000_0010; bus_read = 1'b1;
        s1_start = 1'b1;
        for (int c = 0; c < W + 4; c++) begin
            @(negedge clk);
            check(!bus_ack && !bus_binh && !per_en && !s1_ack && !s1_en,
                  "R11 outputs held in reset", 32'({bus_ack, per_en, s1_ack}), 32'h0);
        end
        bus_start = 1'b0; s1_start = 1'b0; bus_addr = '0;
        rst_n = 1'b1;
        for (int c = 0; c < W + 4; c++) begin
            @(negedge clk);
            check(!bus_ack && !per_en, "R11 no pending access after reset",
                  32'({bus_ack, per_en}), 32'h0);
        end

        // Vector table.
        for (int i = 0; i < NV; i++) run_vec(VECS[i]);

        // R9: refused burst followed by back-to-back single accesses.
        run_vec(VECS[11]);
        run_vec(VECS[12]);
        run_vec(VECS[1]);
        run_vec(VECS[10]);

        // R2 boundary: zero wait states gives acknowledge in cycle 2.
        @(negedge clk);
        s1_start = 1'b1;
        @(negedge clk);
        s1_start = 1'b0;
        check(s1_en && !s1_ack, "R7 zero-wait issue cycle 1", 32'({s1_en, s1_ack}), 32'h2);
        @(negedge clk);
        check(s1_ack && !s1_binh, "R2 zero-wait ack cycle 2", 32'(s1_ack), 32'h1);
        check(s1_rdata == 32'hCAFEF00D, "R3 zero-wait word read", s1_rdata, 32'hCAFEF00D);
        @(negedge clk);
        check(!s1_ack && s1_rdata == 32'h0, "R2 zero-wait ack single pulse", 32'(s1_ack), 32'h0);

        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end
endmodule